// File: doc/BRIEF.md
# Peripheral bus address window decoder

This block decides, for each host cycle, whether the cycle belongs to a side-band peripheral bus. Software programs a small register file: one 32-bit decode-enable word, four generic I/O windows (16-bit base, 8-bit length-minus-one), and four generic memory windows (32-bit base, 16-bit length-minus-one). Three fixed legacy I/O port groups have their own enable bits in the same word.

A combinational lookup port takes a valid strobe, a cycle type (I/O or memory) and an address. It returns a hit flag, a legacy flag and the 2-bit index of the winning window. Register writes are single-cycle and take effect on the lookup in the following cycle. Registers read back combinationally at their own offsets, so software can find a free window or an existing base before it claims one.

Top module: `pbus_win_decoder`

## Requirements
- R1: After reset every enable bit, base and size register reads as zero and no lookup hits.
- R2: A write to the enable register (offset 0) replaces all 32 bits exactly, and the same value reads back. Without a write the register holds its value.
- R3: A window whose enable bit is clear never matches. I/O window i is enabled by bit i, and memory window i by bit 8+i.
- R4: Enable bit 16 decodes I/O port 0x0080, bit 17 decodes ports 0x0060 and 0x0064, and bit 18 decodes ports 0x002E and 0x002F. No other address matches these decodes, and memory cycles never do. A legacy hit drives lk_legacy=1, lk_hit=1 and lk_idx=0.
- R5: An I/O cycle matches generic window i when base <= addr[15:0] <= base + size, summed at 17 bits so the window never wraps past 0xFFFF.
- R6: A memory cycle matches generic window i when base <= addr <= base + size, summed at 33 bits so the window never wraps past 0xFFFFFFFF.
- R7: A legacy hit takes priority over generic I/O windows. Among several matching generic windows, the lowest index is reported.
- R8: A size write to a window that is already enabled changes the decoded range on the next lookup, without the window being disabled.
- R9: While lk_valid is low, lk_hit, lk_legacy and lk_idx are all zero.
- R10: I/O window i reads at offset 1+i as {8'h00, size, base}. Memory window i has its base at offset 8+2i and its size in bits 15:0 of offset 9+2i. Unmapped offsets read zero.
- R11: I/O cycles never match memory windows, and memory cycles never match I/O windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_valid | input | 1 | Lookup qualifier |
| lk_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| lk_addr | input | 32 | Cycle address (I/O uses bits 15:0) |
| lk_hit | output | 1 | Cycle is claimed by a window or legacy port |
| lk_legacy | output | 1 | Claimed by a fixed legacy port decode |
| lk_idx | output | 2 | Index of the winning generic window |

## Verification
On every cycle, the assertions check that an idle lookup reports nothing, that a legacy hit is always an I/O hit, and that any generic hit points at an enabled window whose base lies at or below the address. They also check that the enable word follows each write exactly and otherwise holds. Only the bench's scenarios can show the range boundaries: the 17-bit and 33-bit no-wrap ends, the lowest-index choice among overlapping windows, an enlargement taking effect in place, and the exact set of legacy port addresses.

// File: rtl/pbus_win_pkg.sv
package pbus_win_pkg;
  // enable word bit groups
  localparam int EN_IO_LSB  = 0;
  localparam int EN_MM_LSB  = 8;
  localparam int EN_LEG_LSB = 16;
  localparam int N_LEG      = 3;
  // register word offsets
  localparam int REG_EN  = 0;
  localparam int REG_IO0 = 1;
  localparam int REG_MM0 = 8;
  // fixed legacy ports
  localparam logic [15:0] PORT_POST  = 16'h0080;
  localparam logic [15:0] PORT_KBC_A = 16'h0060;
  localparam logic [15:0] PORT_KBC_B = 16'h0064;
  localparam logic [15:0] PORT_SIO_A = 16'h002E;
  localparam logic [15:0] PORT_SIO_B = 16'h002F;

  function automatic logic [N_LEG-1:0] legacy_match(input logic [15:0] a,
                                                    input logic [N_LEG-1:0] en);
    logic [N_LEG-1:0] m;
    m[0] = (a == PORT_POST);
    m[1] = (a == PORT_KBC_A) || (a == PORT_KBC_B);
    m[2] = (a == PORT_SIO_A) || (a == PORT_SIO_B);
    return m & en;
  endfunction
endpackage

// File: rtl/pbus_win_regs.sv
module pbus_win_regs
  import pbus_win_pkg::*;
#(
  parameter int N_IO  = 4,
  parameter int N_MM  = 4,
  parameter int IO_AW = 16,
  parameter int IO_SW = 8,
  parameter int MM_AW = 32,
  parameter int MM_SW = 16,
  parameter int RA_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RA_W-1:0]  addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [31:0]      en_o,
  output logic [IO_AW-1:0] io_base_o [N_IO],
  output logic [IO_SW-1:0] io_size_o [N_IO],
  output logic [MM_AW-1:0] mm_base_o [N_MM],
  output logic [MM_SW-1:0] mm_size_o [N_MM]
);
  logic [31:0]      en_q,      en_d;
  logic [IO_AW-1:0] io_base_q [N_IO], io_base_d [N_IO];
  logic [IO_SW-1:0] io_size_q [N_IO], io_size_d [N_IO];
  logic [MM_AW-1:0] mm_base_q [N_MM], mm_base_d [N_MM];
  logic [MM_SW-1:0] mm_size_q [N_MM], mm_size_d [N_MM];

  // next-state: single-word writes
  always_comb begin
    en_d      = en_q;
    io_base_d = io_base_q;
    io_size_d = io_size_q;
    mm_base_d = mm_base_q;
    mm_size_d = mm_size_q;
    if (addr == RA_W'(REG_EN)) en_d = wdata;
    for (int i = 0; i < N_IO; i++) begin
      if (addr == RA_W'(REG_IO0 + i)) begin
        io_base_d[i] = wdata[IO_AW-1:0];
        io_size_d[i] = wdata[16 +: IO_SW];
      end
    end
    for (int i = 0; i < N_MM; i++) begin
      if (addr == RA_W'(REG_MM0 + 2*i))     mm_base_d[i] = wdata[MM_AW-1:0];
      if (addr == RA_W'(REG_MM0 + 2*i + 1)) mm_size_d[i] = wdata[MM_SW-1:0];
    end
  end

  // registers with write as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < N_IO; i++) begin
        io_base_q[i] <= '0;
        io_size_q[i] <= '0;
      end
      for (int i = 0; i < N_MM; i++) begin
        mm_base_q[i] <= '0;
        mm_size_q[i] <= '0;
      end
    end else if (we) begin
      en_q      <= en_d;
      io_base_q <= io_base_d;
      io_size_q <= io_size_d;
      mm_base_q <= mm_base_d;
      mm_size_q <= mm_size_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == RA_W'(REG_EN)) rdata = en_q;
    for (int i = 0; i < N_IO; i++) begin
      if (addr == RA_W'(REG_IO0 + i))
        rdata = 32'(io_base_q[i]) | (32'(io_size_q[i]) << 16);
    end
    for (int i = 0; i < N_MM; i++) begin
      if (addr == RA_W'(REG_MM0 + 2*i))     rdata = 32'(mm_base_q[i]);
      if (addr == RA_W'(REG_MM0 + 2*i + 1)) rdata = 32'(mm_size_q[i]);
    end
  end

  assign en_o      = en_q;
  assign io_base_o = io_base_q;
  assign io_size_o = io_size_q;
  assign mm_base_o = mm_base_q;
  assign mm_size_o = mm_size_q;

  AST_EN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_W'(REG_EN)) |=> (en_q == $past(wdata))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q)); // R2
endmodule

// File: rtl/pbus_win_match.sv
module pbus_win_match #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic [N-1:0]  en,
  input  logic [AW-1:0] base [N],
  input  logic [SW-1:0] size [N],
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  match
);
  for (genvar g = 0; g < N; g++) begin : g_win
    logic [AW:0] last;
    // one extra bit: the window end never wraps to zero
    assign last     = {1'b0, base[g]} + (AW+1)'(size[g]);
    assign match[g] = en[g] && (addr >= base[g]) && ({1'b0, addr} <= last);
  end
endmodule

// File: rtl/pbus_prio_enc.sv
module pbus_prio_enc #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pbus_win_decoder.sv
module pbus_win_decoder
  import pbus_win_pkg::*;
#(
  parameter int N_IO  = 4,
  parameter int N_MM  = 4,
  parameter int IO_AW = 16,
  parameter int IO_SW = 8,
  parameter int MM_AW = 32,
  parameter int MM_SW = 16,
  parameter int RA_W  = 6,
  localparam int N_MAX = (N_IO > N_MM) ? N_IO : N_MM,
  localparam int IDX_W = (N_MAX > 1) ? $clog2(N_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             lk_valid,
  input  logic             lk_is_mem,
  input  logic [MM_AW-1:0] lk_addr,
  output logic             lk_hit,
  output logic             lk_legacy,
  output logic [IDX_W-1:0] lk_idx
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [31:0]      en_w;
  logic [IO_AW-1:0] io_base_w [N_IO];
  logic [IO_SW-1:0] io_size_w [N_IO];
  logic [MM_AW-1:0] mm_base_w [N_MM];
  logic [MM_SW-1:0] mm_size_w [N_MM];

  pbus_win_regs #(
    .N_IO(N_IO), .N_MM(N_MM), .IO_AW(IO_AW), .IO_SW(IO_SW),
    .MM_AW(MM_AW), .MM_SW(MM_SW), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sn), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en_o(en_w),
    .io_base_o(io_base_w), .io_size_o(io_size_w),
    .mm_base_o(mm_base_w), .mm_size_o(mm_size_w)
  );

  logic [N_IO-1:0]  io_match;
  logic [N_MM-1:0]  mm_match;
  logic [N_LEG-1:0] leg_match;
  logic             io_any, mm_any, leg_any;
  logic [IDX_W-1:0] io_idx, mm_idx;

  pbus_win_match #(.N(N_IO), .AW(IO_AW), .SW(IO_SW)) u_io_match (
    .en(en_w[EN_IO_LSB +: N_IO]), .base(io_base_w), .size(io_size_w),
    .addr(lk_addr[IO_AW-1:0]), .match(io_match)
  );

  pbus_win_match #(.N(N_MM), .AW(MM_AW), .SW(MM_SW)) u_mm_match (
    .en(en_w[EN_MM_LSB +: N_MM]), .base(mm_base_w), .size(mm_size_w),
    .addr(lk_addr), .match(mm_match)
  );

  pbus_prio_enc #(.N(N_IO), .IW(IDX_W)) u_io_prio (
    .req(io_match), .any(io_any), .idx(io_idx)
  );

  pbus_prio_enc #(.N(N_MM), .IW(IDX_W)) u_mm_prio (
    .req(mm_match), .any(mm_any), .idx(mm_idx)
  );

  assign leg_match = legacy_match(lk_addr[15:0], en_w[EN_LEG_LSB +: N_LEG]);
  assign leg_any   = |leg_match;

  always_comb begin
    lk_hit    = 1'b0;
    lk_legacy = 1'b0;
    lk_idx    = '0;
    if (lk_valid) begin
      if (lk_is_mem) begin
        lk_hit = mm_any;
        lk_idx = mm_idx;
      end else if (leg_any) begin
        lk_hit    = 1'b1;
        lk_legacy = 1'b1;
      end else begin
        lk_hit = io_any;
        lk_idx = io_idx;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !lk_valid |-> (!lk_hit && !lk_legacy && lk_idx == '0)); // R9
  AST_LEGACY_IS_IO: assert property (@(posedge clk) disable iff (!rst_sn)
    lk_legacy |-> (lk_hit && !lk_is_mem && lk_idx == '0)); // R4
  AST_IO_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_sn)
    (lk_hit && !lk_legacy && !lk_is_mem) |->
      (en_w[EN_IO_LSB + int'(lk_idx)] && io_base_w[lk_idx] <= lk_addr[IO_AW-1:0])); // R3
  AST_MM_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_sn)
    (lk_hit && lk_is_mem) |->
      (en_w[EN_MM_LSB + int'(lk_idx)] && mm_base_w[lk_idx] <= lk_addr)); // R11
endmodule

// File: tb/pbus_win_decoder_tb.sv
module pbus_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lk_valid, lk_is_mem;
  logic [31:0] lk_addr;
  logic        lk_hit, lk_legacy;
  logic [1:0]  lk_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side record of what was programmed
  logic [31:0] m_en;
  logic [15:0] m_iob [4];
  logic [7:0]  m_ios [4];
  logic [31:0] m_mmb [4];
  logic [15:0] m_mms [4];

  always #4 clk = ~clk;

  pbus_win_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_is_mem(lk_is_mem), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_legacy(lk_legacy), .lk_idx(lk_idx)
  );

  function automatic logic [3:0] model(input bit v, input bit mem, input logic [31:0] a);
    if (!v) return 4'b0000;
    if (mem) begin
      for (int i = 0; i < 4; i++)
        if (m_en[8+i] && {1'b0, a} >= {1'b0, m_mmb[i]} &&
            {1'b0, a} <= {1'b0, m_mmb[i]} + 33'(m_mms[i]))
          return {2'b10, 2'(i)};
      return 4'b0000;
    end
    if ((m_en[16] && a[15:0] == 16'h0080) ||
        (m_en[17] && (a[15:0] == 16'h0060 || a[15:0] == 16'h0064)) ||
        (m_en[18] && (a[15:0] == 16'h002E || a[15:0] == 16'h002F)))
      return 4'b1100;
    for (int i = 0; i < 4; i++)
      if (m_en[i] && {1'b0, a[15:0]} >= {1'b0, m_iob[i]} &&
          {1'b0, a[15:0]} <= {1'b0, m_iob[i]} + 17'(m_ios[i]))
        return {2'b10, 2'(i)};
    return 4'b0000;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = 6'(a);
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read @%0d actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic lk_chk(input bit v, input bit mem, input logic [31:0] a, input string req);
    logic [3:0] exp;
    @(negedge clk);
    lk_valid = v; lk_is_mem = mem; lk_addr = a;
    #1;
    exp = model(v, mem, a);
    checks++;
    if ({lk_hit, lk_legacy, lk_idx} !== exp) begin
      fails++;
      $display("FAIL %s lookup v=%0b mem=%0b addr=%h actual=%b expected=%b",
               req, v, mem, a, {lk_hit, lk_legacy, lk_idx}, exp);
    end
  endtask

  task automatic set_en(input logic [31:0] v);
    m_en = v; wr(0, v);
  endtask
  task automatic set_io(input int i, input logic [15:0] b, input logic [7:0] s);
    m_iob[i] = b; m_ios[i] = s; wr(1 + i, {8'h00, s, b});
  endtask
  task automatic set_mm(input int i, input logic [31:0] b, input logic [15:0] s);
    m_mmb[i] = b; m_mms[i] = s; wr(8 + 2*i, b); wr(9 + 2*i, {16'h0, s});
  endtask

  function automatic string tag_of(input logic [3:0] e, input bit mem);
    if (e[2]) return "R4 R7";
    if (!e[3]) return "R3 R11";
    return mem ? "R6" : "R5 R7";
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = '0;
    for (int i = 0; i < 4; i++) begin
      m_iob[i] = '0; m_ios[i] = '0; m_mmb[i] = '0; m_mms[i] = '0;
    end
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_is_mem = 1'b0; lk_addr = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    rd_chk(0, 32'h0, "R1");
    rd_chk(1, 32'h0, "R1");
    rd_chk(9, 32'h0, "R1");
    lk_chk(1, 0, 32'h80, "R1");
    lk_chk(1, 1, 32'h0, "R1");
    lk_chk(1, 0, 32'h0, "R1");

    // R2: exact replacement of enable word
    set_en(32'hA5A5_5A5A);
    rd_chk(0, 32'hA5A5_5A5A, "R2");
    set_en(32'h0000_0000);
    rd_chk(0, 32'h0, "R2");

    // R10: register map readback
    wr(1, 32'hFFFF_FFFF); m_iob[0] = 16'hFFFF; m_ios[0] = 8'hFF;
    rd_chk(1, 32'h00FF_FFFF, "R10");
    set_mm(2, 32'h1234_5678, 16'hBEEF);
    rd_chk(12, 32'h1234_5678, "R10");
    rd_chk(13, 32'h0000_BEEF, "R10");
    rd_chk(32, 32'h0, "R10");
    rd_chk(6, 32'h0, "R10");

    // R3: programmed but disabled windows do not match
    set_io(0, 16'h0300, 8'h0F);
    lk_chk(1, 0, 32'h0305, "R3");
    lk_chk(1, 1, 32'h1234_5678, "R3");

    // R4: legacy ports, one group at a time
    set_en(32'h0001_0000);
    lk_chk(1, 0, 32'h0080, "R4");
    lk_chk(1, 0, 32'h0081, "R4");
    lk_chk(1, 0, 32'h0060, "R4");
    lk_chk(1, 1, 32'h0080, "R4");
    set_en(32'h0002_0000);
    lk_chk(1, 0, 32'h0064, "R4");
    lk_chk(1, 0, 32'h0060, "R4");
    lk_chk(1, 0, 32'h0062, "R4");
    lk_chk(1, 0, 32'h0080, "R4");
    set_en(32'h0004_0000);
    lk_chk(1, 0, 32'h002E, "R4");
    lk_chk(1, 0, 32'h002F, "R4");
    lk_chk(1, 0, 32'h0030, "R4");

    // R5: I/O window at top of space does not wrap
    set_io(0, 16'hFFF0, 8'hFF);
    set_en(32'h0000_0001);
    lk_chk(1, 0, 32'h0000_FFFF, "R5");
    lk_chk(1, 0, 32'h0000_FFF0, "R5");
    lk_chk(1, 0, 32'h0000_FFEF, "R5");
    lk_chk(1, 0, 32'h0000_0005, "R5");

    // R6: memory window at top of space does not wrap
    set_mm(1, 32'hFFFF_F000, 16'hFFFF);
    set_en(32'h0000_0200);
    lk_chk(1, 1, 32'hFFFF_FFFF, "R6");
    lk_chk(1, 1, 32'hFFFF_F000, "R6");
    lk_chk(1, 1, 32'h0000_0000, "R6");
    lk_chk(1, 1, 32'hFFFF_EFFF, "R6");

    // R11: cross-type isolation
    set_io(2, 16'h4000, 8'h10);
    set_mm(3, 32'h0000_4000, 16'h0010);
    set_en(32'h0000_0004);
    lk_chk(1, 1, 32'h0000_4008, "R11");
    lk_chk(1, 0, 32'h0000_4008, "R11");
    set_en(32'h0000_0800);
    lk_chk(1, 0, 32'h0000_4008, "R11");
    lk_chk(1, 1, 32'h0000_4008, "R11");

    // R7: priorities
    set_io(0, 16'h0070, 8'h1F);
    set_io(1, 16'h0078, 8'h1F);
    set_en(32'h0000_0003);
    lk_chk(1, 0, 32'h007C, "R7");
    set_en(32'h0000_0002);
    lk_chk(1, 0, 32'h007C, "R7");
    set_en(32'h0001_0003);
    lk_chk(1, 0, 32'h0080, "R7");
    lk_chk(1, 0, 32'h0081, "R7");

    // R8: enlarge an enabled window in place
    set_io(1, 16'h0500, 8'h0F);
    set_en(32'h0000_0002);
    lk_chk(1, 0, 32'h0520, "R8");
    set_io(1, 16'h0500, 8'h3F);
    lk_chk(1, 0, 32'h0520, "R8");
    lk_chk(1, 0, 32'h0540, "R8");

    // R9: idle lookups report nothing
    lk_chk(0, 0, 32'h0520, "R9");
    lk_chk(0, 1, 32'h0000_4008, "R9");

    // random configurations and lookups
    for (int round = 0; round < 24; round++) begin
      for (int i = 0; i < 4; i++) begin
        set_io(i, ($urandom % 8 == 0) ? 16'hFF80 : 16'($urandom & 32'h0FF0), 8'($urandom));
        set_mm(i, 32'hFED0_0000 + ($urandom & 32'h0003_F000), 16'($urandom));
      end
      set_en($urandom);
      rd_chk(0, m_en, "R2");
      for (int k = 0; k < 80; k++) begin
        logic [31:0] a;
        logic [3:0]  e;
        bit          v, mem;
        int          w;
        v   = ($urandom % 16) != 0;
        mem = $urandom % 2;
        w   = $urandom % 4;
        case ($urandom % 4)
          0: begin
            case ($urandom % 5)
              0: a = 32'h80; 1: a = 32'h60; 2: a = 32'h64;
              3: a = 32'h2E; default: a = 32'h2F;
            endcase
          end
          1: a = {16'h0, m_iob[w]} + ($urandom & 32'h1FF);
          2: a = m_mmb[w] + ($urandom & 32'h1FFFF);
          default: a = $urandom;
        endcase
        e = model(v, mem, a);
        lk_chk(v, mem, a, v ? tag_of(e, mem) : "R9");
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule